// File: doc/BRIEF.md
# Bit-Plane Processing Element Array

This block is a small two-dimensional mesh of one-bit processing elements that all obey the same instruction each cycle. Each element holds an accumulator bit Q, a carry bit C, an activity bit A and a private one-bit-wide local store. A full adder combines Q, C and a third operand. That operand comes from a selectable source (local store, Q, A, a broadcast bit, a neighbour's Q or a neighbour's carry) and can be inverted. The instruction then loads Q, C or A, or writes the local store. A store only takes effect in elements whose A bit is set.

Neighbour Q values wrap around the mesh edges, so whole planes can be rotated. Neighbour carries form a combinational chain along a row or column, so a word laid across one row can be added in a single cycle. At the element where such a chain begins, the broadcast bit is the carry in. A plane port writes all local stores at one address at once. The Q, C and A planes and the store plane at the current address are visible on output ports. Bit k of every plane belongs to the element at row k / COLS, column k % COLS.

Top module: `bp_array`

## Requirements
- R1: After a synchronous active-low reset, every Q and C is 0, every A is 1 and every local store bit reads 0.
- R2: The operand source code is 0 = local store at `ins_addr`, 1 = own Q, 2 = own A, 3 = `bcast`, 4 = neighbour Q, 5 = neighbour carry, and 6 or 7 = constant 0. The operand is XORed with `ins_inv`. With destination 0 and `ins_add` low, Q takes the operand.
- R3: With destination 0 and `ins_add` high, Q takes Q^C^operand and C takes the majority of Q, C and the operand.
- R4: Destination 1 loads C from the operand, so C is set or cleared through source 3.
- R5: Destination 2 loads A from the operand and leaves Q and C unchanged.
- R6: Destination 3 writes the operand (`ins_msel`=0) or the adder sum (`ins_msel`=1) into the store at `ins_addr`, only in elements with A=1. Q, C and A are unchanged.
- R7: Neighbour direction code 0 = row-1, 1 = col+1, 2 = row+1, 3 = col-1. Neighbour Q wraps at all edges.
- R8: With source 5, an element's operand is the carry out of the adjacent element in the chosen direction in the same cycle, computed under the same instruction. At the edge where the chain starts, `bcast` is used instead, and the chain does not wrap.
- R9: With `ins_en` low, Q, C, A and the store are not changed by the instruction fields.
- R10: `plane_we` writes `plane_wdata` into every store at `ins_addr` regardless of A, and wins over an instruction store in the same cycle.
- R11: `rd_plane` shows the store contents at `ins_addr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_en | input | 1 | Instruction enable |
| ins_src | input | 3 | Operand source code |
| ins_dir | input | 2 | Neighbour direction code |
| ins_inv | input | 1 | Invert operand |
| ins_dst | input | 2 | Destination: 0 Q, 1 C, 2 A, 3 store |
| ins_add | input | 1 | Perform add when destination is Q |
| ins_msel | input | 1 | Store data: 0 operand, 1 sum |
| ins_addr | input | AW | Local store bit address |
| bcast | input | 1 | Broadcast bit and chain edge carry |
| plane_we | input | 1 | Plane write enable |
| plane_wdata | input | NPE | Plane write data, one bit per element |
| q_plane | output | NPE | All Q bits |
| c_plane | output | NPE | All C bits |
| a_plane | output | NPE | All A bits |
| rd_plane | output | NPE | Store bits at ins_addr |

## Verification
The store-mask and plane-write properties only judge the cycle after a write when `ins_addr` is held, because `rd_plane` follows the address. The other properties assume that the instruction fields sampled at a clock edge are the ones that take effect. The stimulus changes every input only at the falling edge and keeps each instruction steady through the next rising edge. Random instruction streams often repeat the same address and sometimes assert `plane_we` together with a store, so that masking and priority are both exercised.

// File: rtl/bp_pkg.sv
// Shared encodings for the bit-plane element array.
// Assumes all elements receive the same decoded control word every cycle.
package bp_pkg;

    typedef enum logic [2:0] {
        SRC_MEM    = 3'd0,
        SRC_Q      = 3'd1,
        SRC_ACT    = 3'd2,
        SRC_BCAST  = 3'd3,
        SRC_NBR_Q  = 3'd4,
        SRC_NBR_CY = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        DIR_N = 2'd0,
        DIR_E = 2'd1,
        DIR_S = 2'd2,
        DIR_W = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        DST_Q   = 2'd0,
        DST_C   = 2'd1,
        DST_ACT = 2'd2,
        DST_MEM = 2'd3
    } dst_e;

    localparam int NDIR = 4;

    typedef struct packed {
        logic en;
        src_e src;
        dir_e dir;
        logic inv;
        dst_e dst;
        logic add;
        logic msel;
    } ctl_t;

endpackage

// File: rtl/bp_opmux.sv
// Operand selector for one element: picks the third adder input and applies
// the optional inversion. Assumes neighbour vectors are indexed by dir_e.
module bp_opmux
    import bp_pkg::*;
(
    input  src_e            src,
    input  dir_e            dir,
    input  logic            inv,
    input  logic            mem_bit,
    input  logic            q,
    input  logic            a,
    input  logic            bcast,
    input  logic [NDIR-1:0] nbr_q,
    input  logic [NDIR-1:0] nbr_cy,
    output logic            opnd
);

    logic raw;

    // Select the raw operand bit by source code.
    always_comb begin
        case (src)
            SRC_MEM:    raw = mem_bit;
            SRC_Q:      raw = q;
            SRC_ACT:    raw = a;
            SRC_BCAST:  raw = bcast;
            SRC_NBR_Q:  raw = nbr_q[dir];
            SRC_NBR_CY: raw = nbr_cy[dir];
            default:    raw = 1'b0;
        endcase
    end

    // Apply optional inversion.
    assign opnd = raw ^ inv;

endmodule

// File: rtl/bp_adder.sv
// One-bit full adder plus one carry-chain output per direction. Each chain
// output assumes the operand came from that direction's incoming carry, so
// chains in different directions never feed each other.
module bp_adder
    import bp_pkg::*;
(
    input  logic            q,
    input  logic            c,
    input  logic            opnd,
    input  logic            inv,
    input  logic [NDIR-1:0] nbr_cy,
    output logic            sum,
    output logic            cout,
    output logic [NDIR-1:0] cy_dir
);

    // Sum and carry for the selected operand.
    assign sum  = q ^ c ^ opnd;
    assign cout = (q & c) | (q & opnd) | (c & opnd);

    // Per-direction carry outputs forming independent ripple chains.
    for (genvar d = 0; d < NDIR; d++) begin : g_chain
        logic m;
        assign m         = nbr_cy[d] ^ inv;
        assign cy_dir[d] = (q & c) | (q & m) | (c & m);
    end

endmodule

// File: rtl/bp_pe.sv
// One bit-plane element: Q, C, A registers, a DEPTH-bit local store, operand
// selector and adder. Assumes addr < DEPTH (DEPTH a power of two).
module bp_pe
    import bp_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ctl_t            ctl,
    input  logic [AW-1:0]   addr,
    input  logic            bcast,
    input  logic [NDIR-1:0] nbr_q,
    input  logic [NDIR-1:0] nbr_cy,
    input  logic            plane_we,
    input  logic            plane_bit,
    output logic            q,
    output logic            c,
    output logic            a,
    output logic            rd_bit,
    output logic [NDIR-1:0] cy_dir
);

    logic [DEPTH-1:0] mem_r;
    logic             opnd;
    logic             sum;
    logic             cout;

    // Asynchronous read of the addressed store bit.
    assign rd_bit = mem_r[addr];

    bp_opmux u_mux (
        .src    (ctl.src),
        .dir    (ctl.dir),
        .inv    (ctl.inv),
        .mem_bit(rd_bit),
        .q      (q),
        .a      (a),
        .bcast  (bcast),
        .nbr_q  (nbr_q),
        .nbr_cy (nbr_cy),
        .opnd   (opnd)
    );

    bp_adder u_add (
        .q     (q),
        .c     (c),
        .opnd  (opnd),
        .inv   (ctl.inv),
        .nbr_cy(nbr_cy),
        .sum   (sum),
        .cout  (cout),
        .cy_dir(cy_dir)
    );

    // Register update for Q, C and A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
            c <= 1'b0;
            a <= 1'b1;
        end else if (ctl.en) begin
            case (ctl.dst)
                DST_Q: begin
                    if (ctl.add) begin
                        q <= sum;
                        c <= cout;
                    end else begin
                        q <= opnd;
                    end
                end
                DST_C:   c <= opnd;
                DST_ACT: a <= opnd;
                default: ;
            endcase
        end
    end

    // Local store write: plane port first, else activity-gated store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_r <= '0;
        end else if (plane_we) begin
            mem_r[addr] <= plane_bit;
        end else if (ctl.en && ctl.dst == DST_MEM && a) begin
            mem_r[addr] <= ctl.msel ? sum : opnd;
        end
    end

endmodule

// File: rtl/bp_array_chk.sv
// Property checker for the element array, bound to bp_array.
// Assumes inputs are stable around the rising clock edge.
module bp_array_chk #(
    parameter int NPE = 32,
    parameter int AW  = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ins_en,
    input logic [2:0]     ins_src,
    input logic           ins_inv,
    input logic [1:0]     ins_dst,
    input logic           ins_add,
    input logic [AW-1:0]  ins_addr,
    input logic           bcast,
    input logic           plane_we,
    input logic [NPE-1:0] plane_wdata,
    input logic [NPE-1:0] q_plane,
    input logic [NPE-1:0] c_plane,
    input logic [NPE-1:0] a_plane,
    input logic [NPE-1:0] rd_plane
);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_en |=> ($stable(q_plane) && $stable(c_plane) && $stable(a_plane)));

    // R5
    act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_dst == 2'd2) |=> ($stable(q_plane) && $stable(c_plane)));

    // R4
    carry_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_dst == 2'd1 && ins_src == 3'd3)
        |=> (c_plane == {NPE{$past(bcast ^ ins_inv)}}));

    // R2
    q_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_dst == 2'd0 && !ins_add && ins_src == 3'd3)
        |=> (q_plane == {NPE{$past(bcast ^ ins_inv)}}));

    // R6
    store_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_dst == 2'd3 && !plane_we)
        |=> ((ins_addr != $past(ins_addr)) ||
             (((rd_plane ^ $past(rd_plane)) & ~$past(a_plane)) == '0)));

    // R6
    store_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && ins_dst == 2'd3)
        |=> ($stable(q_plane) && $stable(c_plane) && $stable(a_plane)));

    // R10
    plane_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        plane_we |=> ((ins_addr != $past(ins_addr)) || (rd_plane == $past(plane_wdata))));

endmodule

bind bp_array bp_array_chk #(.NPE(NPE), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_en     (ins_en),
    .ins_src    (ins_src),
    .ins_inv    (ins_inv),
    .ins_dst    (ins_dst),
    .ins_add    (ins_add),
    .ins_addr   (ins_addr),
    .bcast      (bcast),
    .plane_we   (plane_we),
    .plane_wdata(plane_wdata),
    .q_plane    (q_plane),
    .c_plane    (c_plane),
    .a_plane    (a_plane),
    .rd_plane   (rd_plane)
);

// File: rtl/bp_array.sv
// ROWS x COLS mesh of bit-plane elements sharing one broadcast instruction.
// Neighbour Q wraps at all edges. Carry chains run one per direction, start
// at the edge with bcast as carry in, and do not wrap.
// Plane bit k belongs to row k / COLS, column k % COLS.
module bp_array
    import bp_pkg::*;
#(
    parameter  int ROWS  = 4,
    parameter  int COLS  = 8,
    parameter  int DEPTH = 16,
    localparam int NPE   = ROWS * COLS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_en,
    input  logic [2:0]     ins_src,
    input  logic [1:0]     ins_dir,
    input  logic           ins_inv,
    input  logic [1:0]     ins_dst,
    input  logic           ins_add,
    input  logic           ins_msel,
    input  logic [AW-1:0]  ins_addr,
    input  logic           bcast,
    input  logic           plane_we,
    input  logic [NPE-1:0] plane_wdata,
    output logic [NPE-1:0] q_plane,
    output logic [NPE-1:0] c_plane,
    output logic [NPE-1:0] a_plane,
    output logic [NPE-1:0] rd_plane
);

    ctl_t           ctl;
    logic [NPE-1:0] cyo_n;
    logic [NPE-1:0] cyo_e;
    logic [NPE-1:0] cyo_s;
    logic [NPE-1:0] cyo_w;

    // Pack the broadcast instruction fields into one control word.
    always_comb begin
        ctl.en   = ins_en;
        ctl.src  = src_e'(ins_src);
        ctl.dir  = dir_e'(ins_dir);
        ctl.inv  = ins_inv;
        ctl.dst  = dst_e'(ins_dst);
        ctl.add  = ins_add;
        ctl.msel = ins_msel;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int K  = r * COLS + c;
            localparam int KN = ((r + ROWS - 1) % ROWS) * COLS + c;
            localparam int KS = ((r + 1) % ROWS) * COLS + c;
            localparam int KE = r * COLS + (c + 1) % COLS;
            localparam int KW = r * COLS + (c + COLS - 1) % COLS;

            logic [NDIR-1:0] nbq;
            logic [NDIR-1:0] nbc;
            logic [NDIR-1:0] cyo;

            // Wrapped neighbour Q, indexed by direction code.
            assign nbq = {q_plane[KW], q_plane[KS], q_plane[KE], q_plane[KN]};

            // Incoming chain carries; the chain's first element takes bcast.
            if (r == 0) begin : g_en
                assign nbc[DIR_N] = bcast;
            end else begin : g_in
                assign nbc[DIR_N] = cyo_n[KN];
            end
            if (c == COLS - 1) begin : g_ee
                assign nbc[DIR_E] = bcast;
            end else begin : g_ie
                assign nbc[DIR_E] = cyo_e[KE];
            end
            if (r == ROWS - 1) begin : g_es
                assign nbc[DIR_S] = bcast;
            end else begin : g_is
                assign nbc[DIR_S] = cyo_s[KS];
            end
            if (c == 0) begin : g_ew
                assign nbc[DIR_W] = bcast;
            end else begin : g_iw
                assign nbc[DIR_W] = cyo_w[KW];
            end

            bp_pe #(.DEPTH(DEPTH)) u_pe (
                .clk      (clk),
                .rst_n    (rst_n),
                .ctl      (ctl),
                .addr     (ins_addr),
                .bcast    (bcast),
                .nbr_q    (nbq),
                .nbr_cy   (nbc),
                .plane_we (plane_we),
                .plane_bit(plane_wdata[K]),
                .q        (q_plane[K]),
                .c        (c_plane[K]),
                .a        (a_plane[K]),
                .rd_bit   (rd_plane[K]),
                .cy_dir   (cyo)
            );

            // Publish this element's chain carries to the planes.
            assign cyo_n[K] = cyo[DIR_N];
            assign cyo_e[K] = cyo[DIR_E];
            assign cyo_s[K] = cyo[DIR_S];
            assign cyo_w[K] = cyo[DIR_W];
        end
    end

endmodule

// File: tb/bp_array_tb.sv
// Self-checking bench: directed corners plus seeded random instruction
// streams, compared against a plane-level reference model.
module bp_array_tb;

    localparam int ROWS  = 4;
    localparam int COLS  = 8;
    localparam int DEPTH = 16;
    localparam int NPE   = ROWS * COLS;
    localparam int AW    = $clog2(DEPTH);

    logic           clk = 1'b0;
    logic           rst_n;
    logic           ins_en;
    logic [2:0]     ins_src;
    logic [1:0]     ins_dir;
    logic           ins_inv;
    logic [1:0]     ins_dst;
    logic           ins_add;
    logic           ins_msel;
    logic [AW-1:0]  ins_addr;
    logic           bcast;
    logic           plane_we;
    logic [NPE-1:0] plane_wdata;
    logic [NPE-1:0] q_plane, c_plane, a_plane, rd_plane;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [NPE-1:0] q_m, c_m, a_m;
    logic [NPE-1:0] mem_m [DEPTH];

    always #10 clk = ~clk;

    bp_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_src(ins_src),
        .ins_dir(ins_dir), .ins_inv(ins_inv), .ins_dst(ins_dst),
        .ins_add(ins_add), .ins_msel(ins_msel), .ins_addr(ins_addr),
        .bcast(bcast), .plane_we(plane_we), .plane_wdata(plane_wdata),
        .q_plane(q_plane), .c_plane(c_plane), .a_plane(a_plane),
        .rd_plane(rd_plane)
    );

    function automatic logic maj3(logic x, logic y, logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    function automatic int nbr_idx(int k, logic [1:0] d);
        int r = k / COLS;
        int c = k % COLS;
        case (d)
            2'd0:    return ((r + ROWS - 1) % ROWS) * COLS + c;
            2'd1:    return r * COLS + (c + 1) % COLS;
            2'd2:    return ((r + 1) % ROWS) * COLS + c;
            default: return r * COLS + (c + COLS - 1) % COLS;
        endcase
    endfunction

    task automatic check_vec(string tag, string what, logic [NPE-1:0] act, logic [NPE-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model: apply the currently driven instruction to the model.
    task automatic model_apply();
        logic [NPE-1:0] opv, sumv, cov;
        logic [NPE-1:0] chain;
        logic           cin;
        int             k;
        opv   = '0;
        chain = '0;
        for (int i = 0; i < NPE; i++) begin
            case (ins_src)
                3'd0:    opv[i] = mem_m[ins_addr][i];
                3'd1:    opv[i] = q_m[i];
                3'd2:    opv[i] = a_m[i];
                3'd3:    opv[i] = bcast;
                3'd4:    opv[i] = q_m[nbr_idx(i, ins_dir)];
                default: opv[i] = 1'b0;
            endcase
            opv[i] = opv[i] ^ ins_inv;
        end
        if (ins_src == 3'd5) begin
            case (ins_dir)
                2'd3: for (int r = 0; r < ROWS; r++)
                          for (int c = 0; c < COLS; c++) begin
                              k = r * COLS + c;
                              cin = (c == 0) ? bcast : chain[k - 1];
                              opv[k] = cin ^ ins_inv;
                              chain[k] = maj3(q_m[k], c_m[k], opv[k]);
                          end
                2'd1: for (int r = 0; r < ROWS; r++)
                          for (int c = COLS - 1; c >= 0; c--) begin
                              k = r * COLS + c;
                              cin = (c == COLS - 1) ? bcast : chain[k + 1];
                              opv[k] = cin ^ ins_inv;
                              chain[k] = maj3(q_m[k], c_m[k], opv[k]);
                          end
                2'd0: for (int c = 0; c < COLS; c++)
                          for (int r = 0; r < ROWS; r++) begin
                              k = r * COLS + c;
                              cin = (r == 0) ? bcast : chain[k - COLS];
                              opv[k] = cin ^ ins_inv;
                              chain[k] = maj3(q_m[k], c_m[k], opv[k]);
                          end
                default: for (int c = 0; c < COLS; c++)
                          for (int r = ROWS - 1; r >= 0; r--) begin
                              k = r * COLS + c;
                              cin = (r == ROWS - 1) ? bcast : chain[k + COLS];
                              opv[k] = cin ^ ins_inv;
                              chain[k] = maj3(q_m[k], c_m[k], opv[k]);
                          end
            endcase
        end
        for (int i = 0; i < NPE; i++) begin
            sumv[i] = q_m[i] ^ c_m[i] ^ opv[i];
            cov[i]  = maj3(q_m[i], c_m[i], opv[i]);
        end
        if (plane_we) begin
            mem_m[ins_addr] = plane_wdata;
        end else if (ins_en && ins_dst == 2'd3) begin
            for (int i = 0; i < NPE; i++)
                if (a_m[i]) mem_m[ins_addr][i] = ins_msel ? sumv[i] : opv[i];
        end
        if (ins_en) begin
            case (ins_dst)
                2'd0: if (ins_add) begin q_m = sumv; c_m = cov; end else q_m = opv;
                2'd1: c_m = opv;
                2'd2: a_m = opv;
                default: ;
            endcase
        end
    endtask

    // Drive one instruction at a falling edge, then check one cycle later.
    task automatic do_op(input logic en, input logic [2:0] src, input logic [1:0] dir,
                         input logic inv, input logic [1:0] dst, input logic add,
                         input logic msel, input logic [AW-1:0] addr, input logic bc,
                         input logic pwe, input logic [NPE-1:0] pwd, input string tag);
        ins_en = en; ins_src = src; ins_dir = dir; ins_inv = inv; ins_dst = dst;
        ins_add = add; ins_msel = msel; ins_addr = addr; bcast = bc;
        plane_we = pwe; plane_wdata = pwd;
        model_apply();
        @(negedge clk);
        check_vec(tag, "q_plane", q_plane, q_m);
        check_vec(tag, "c_plane", c_plane, c_m);
        check_vec(tag, "a_plane", a_plane, a_m);
        check_vec(tag, "rd_plane", rd_plane, mem_m[ins_addr]);
    endtask

    task automatic idle(input logic [AW-1:0] addr, input string tag);
        do_op(1'b0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, addr, 1'b0, 1'b0, '0, tag);
    endtask

    task automatic pwrite(input logic [AW-1:0] addr, input logic [NPE-1:0] d);
        do_op(1'b0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, addr, 1'b0, 1'b1, d, "R10");
    endtask

    // One-cycle row-wide add: Q=a, C=b, then add with west carry chain.
    task automatic row_add(input logic [NPE-1:0] pa, input logic [NPE-1:0] pb, input logic cin);
        logic [COLS:0] exp;
        pwrite(4'd1, pa);
        pwrite(4'd2, pb);
        do_op(1'b1, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, '0, "R2");
        do_op(1'b1, 3'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd2, 1'b0, 1'b0, '0, "R4");
        do_op(1'b1, 3'd5, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 4'd0, cin, 1'b0, '0, "R8");
        for (int r = 0; r < ROWS; r++) begin
            exp = {1'b0, pa[r*COLS +: COLS]} + {1'b0, pb[r*COLS +: COLS]} + (COLS+1)'(cin);
            checks++;
            if (q_plane[r*COLS +: COLS] !== exp[COLS-1:0] || c_plane[r*COLS + COLS - 1] !== exp[COLS]) begin
                errors++;
                $display("FAIL R8 row %0d sum actual=%b_%h expected=%b_%h", r,
                         c_plane[r*COLS + COLS - 1], q_plane[r*COLS +: COLS], exp[COLS], exp[COLS-1:0]);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NPE-1:0] pa;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ins_en = 0; ins_src = 0; ins_dir = 0; ins_inv = 0; ins_dst = 0;
        ins_add = 0; ins_msel = 0; ins_addr = 0; bcast = 0; plane_we = 0; plane_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q_m = '0; c_m = '0; a_m = '1;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;

        // R1: reset state over every address
        for (int i = 0; i < DEPTH; i++) idle(AW'(i), "R1");

        // R10 / R11: plane writes read back at once
        pa = $urandom;
        pwrite(4'd1, pa);
        check_vec("R11", "rd_plane", rd_plane, pa);
        pwrite(4'd2, $urandom);

        // R5: load A from store plane 1
        do_op(1'b1, 3'd0, 2'd0, 1'b0, 2'd2, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, '0, "R5");
        check_vec("R5", "a_plane", a_plane, pa);
        // R6: store broadcast 1 to address 5 only where A=1
        do_op(1'b1, 3'd3, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 4'd5, 1'b1, 1'b0, '0, "R6");
        check_vec("R6", "masked store", rd_plane, pa);
        // R6: store sum
        do_op(1'b1, 3'd3, 2'd0, 1'b0, 2'd3, 1'b0, 1'b1, 4'd6, 1'b1, 1'b0, '0, "R6");
        // R10: plane write beats instruction store in the same cycle
        do_op(1'b1, 3'd3, 2'd0, 1'b0, 2'd3, 1'b0, 1'b0, 4'd5, 1'b0, 1'b1, 32'h0F0F_0F0F, "R10");
        check_vec("R10", "priority", rd_plane, 32'h0F0F_0F0F);
        // R9: disabled instruction with store fields leaves everything alone
        do_op(1'b0, 3'd3, 2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 4'd5, 1'b1, 1'b0, '0, "R9");
        do_op(1'b0, 3'd3, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 4'd5, 1'b0, 1'b0, '0, "R9");

        // R4: set and clear C through the broadcast source
        do_op(1'b1, 3'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, '0, "R4");
        check_vec("R4", "c set", c_plane, '1);
        do_op(1'b1, 3'd3, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, '0, "R4");
        check_vec("R4", "c clear", c_plane, '0);

        // R7: neighbour Q wrap in all four directions
        for (int d = 0; d < 4; d++) begin
            do_op(1'b1, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, '0, "R2");
            do_op(1'b1, 3'd4, 2'(d), 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, '0, "R7");
        end
        // R2: reserved sources give zero (inverted gives one)
        do_op(1'b1, 3'd6, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, '0, "R2");
        check_vec("R2", "reserved inv", q_plane, '1);
        do_op(1'b1, 3'd7, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, '0, "R2");
        check_vec("R2", "reserved", q_plane, '0);

        // R8: word adds along each row, including full ripple cases
        do_op(1'b1, 3'd3, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, '0, "R5");
        row_add(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        row_add(32'hFF00_FF00, 32'h0000_0000, 1'b1);
        row_add(32'h0000_0000, 32'h0000_0000, 1'b0);
        row_add(32'hFF80_7F01, 32'h0180_80FF, 1'b1);
        for (int i = 0; i < 8; i++) row_add($urandom, $urandom, 1'($urandom));
        // R8: chains in the other directions with random state
        for (int i = 0; i < 16; i++)
            do_op(1'b1, 3'd5, 2'(i % 4), 1'($urandom), 2'd0, 1'b1, 1'b0, 4'd0,
                  1'($urandom), 1'b0, '0, "R8");

        // R3: adds with store operand
        for (int i = 0; i < 16; i++)
            do_op(1'b1, 3'd0, 2'd0, 1'($urandom), 2'd0, 1'b1, 1'b0, AW'($urandom),
                  1'b0, 1'b0, '0, "R3");

        // Random instruction stream (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < 4000; i++) begin
            do_op(($urandom % 8) != 0, 3'($urandom), 2'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), 1'($urandom), AW'($urandom % 4),
                  1'($urandom), ($urandom % 10) == 0, $urandom, "R6");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule